// File: doc/BRIEF.md
# Interrupt Controller Register Port Decoder

This block sits between a byte-wide register bus and the interrupt core of one interrupt-controller slice. It turns byte writes and reads on a two-address command/data pair, plus a separate trigger-mode address, into configuration registers and single-cycle control strobes for the core. The core resolves priority among pending requests. This block only picks the highest-priority in-service line for the non-specific end-of-interrupt commands, using the current rotating priority base.

A write to the command address with bit 4 set starts an initialization run. An init sequencer then walks through four named states:
- `ST_READY`: normal operation.
- `ST_WAIT_BASE`: waits for the vector base.
- `ST_WAIT_CASCADE`: waits for the cascade word.
- `ST_WAIT_MODE`: waits for the optional mode word.

The transitions are:
- Start: any state goes to `ST_WAIT_BASE` on an init write.
- Base taken: `ST_WAIT_BASE` goes to `ST_WAIT_CASCADE`.
- Cascade taken: `ST_WAIT_CASCADE` goes to `ST_WAIT_MODE` when a mode word was requested, otherwise to `ST_READY`.
- Mode taken: `ST_WAIT_MODE` goes to `ST_READY`.

Outside initialization, other command bytes either set read-select, poll and special-mask modes, or carry a 3-bit operation code for end-of-interrupt and rotation. A data-address write in `ST_READY` loads the mask. Reads return the request, in-service or mask register, a poll result, or the trigger-mode register.

Top module: `ictl_port_decoder`

## Requirements
- R1: A command-address write with bit 4 set produces, one clock later, a one-cycle `slice_init` pulse. The same write clears the mask, vector base, priority base and the nest, auto-EOI, rotate, special-mask, read-select and poll modes. It enters `ST_WAIT_BASE` and records data bit 0 as "mode word wanted". It leaves the trigger-mode register unchanged.
- R2: In `ST_WAIT_BASE`, a data-address write stores the byte with its low 3 bits forced to zero as the vector base and moves to `ST_WAIT_CASCADE`.
- R3: In `ST_WAIT_CASCADE`, a data-address write moves to `ST_WAIT_MODE` if a mode word was wanted, otherwise to `ST_READY`. The written byte changes no output register.
- R4: In `ST_WAIT_MODE`, a data-address write sets `nest_mode` from bit 4 and `auto_eoi` from bit 1, then returns to `ST_READY`.
- R5: In `ST_READY`, a data-address write loads `mask_reg` with the byte.
- R6: A command byte with bit 4 clear and bit 3 set is a mode command. Bit 2 arms poll. When bit 1 is set, bit 0 selects the in-service register (1) or the request register (0) for address-0 reads. When bit 6 is set, `special_mask` takes bit 5.
- R7: A command byte with bits 4 and 3 clear carries an operation code in bits 7:5. Codes 0 and 4 set `rot_on_aeoi` to 0 and 1 respectively. Code 2 changes nothing.
- R8: Code 1 pulses `isr_clr` for the highest-priority set bit of `core_isr`. Priority starts at `prio_base` and falls with increasing index modulo 8. When `core_isr` is zero there is no pulse. Code 5 does the same and also sets `prio_base` to that index plus 1 (mod 8).
- R9: Code 3 pulses `isr_clr` with index bits 2:0. Code 7 does the same and sets `prio_base` to bits 2:0 plus 1. Code 6 sets `prio_base` to bits 2:0 plus 1 with no pulse.
- R10: With poll not armed, a read in the same cycle returns the selected in-service or request register at address 0, and `mask_reg` at address 1.
- R11: With poll armed, a read of address 0 or 1 returns `core_pend_idx` (upper bits zero) if `core_pend_valid`, else 7. One clock later poll is disarmed. For a valid result, `isr_clr` and `irr_clr` pulse for that index.
- R12: A write with `bus_trig_sel` high stores the byte ANDed with a slice constant into `trig_mode`. The constant is 0xF8 for a primary slice and 0xDE for a secondary slice. A read with `bus_trig_sel` high returns `trig_mode`.
- R13: Every write takes effect one clock after the strobe. `slice_init`, `isr_clr` and `irr_clr` are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read strobe |
| bus_addr | input | 1 | 0 = command address, 1 = data address |
| bus_trig_sel | input | 1 | Selects the trigger-mode register instead of the command pair |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid in the cycle of `bus_rd` |
| core_irr | input | 8 | Request register from the core |
| core_isr | input | 8 | In-service register from the core |
| core_pend_valid | input | 1 | Core has a deliverable request |
| core_pend_idx | input | 3 | Index of that request |
| slice_init | output | 1 | Pulse: core clears its state and drops its output |
| mask_reg | output | 8 | Interrupt mask |
| vector_base | output | 8 | Vector base, low 3 bits zero |
| nest_mode | output | 1 | Special fully nested mode |
| auto_eoi | output | 1 | Automatic end-of-interrupt |
| rot_on_aeoi | output | 1 | Rotate on automatic end-of-interrupt |
| special_mask | output | 1 | Special mask mode |
| prio_base | output | 3 | Line with highest priority |
| trig_mode | output | 8 | Level-trigger select per line |
| isr_clr | output | 1 | Pulse: clear one in-service bit |
| isr_clr_idx | output | 3 | Index for `isr_clr` / `irr_clr` |
| irr_clr | output | 1 | Pulse: clear one request bit (poll) |

## Verification
The bench builds two instances. One uses the default primary setting (`IS_SECONDARY = 0`) and carries all the sequencing, command and read checks. A second, with `IS_SECONDARY = 1`, shares the same bus, so every trigger-mode write is checked against both the 0xF8 and the 0xDE constants. With the primary instance, initialization runs both with and without the mode word. Rotating end-of-interrupt selection is reached with the priority base at non-zero positions and in-service patterns that wrap past index 7. Poll reads are reached with and without a pending request.

// File: rtl/ictl_pkg.sv
package ictl_pkg;
    localparam int DATA_W = 8;
    localparam int LINES  = 8;
    localparam int IDX_W  = $clog2(LINES);

    typedef enum logic [1:0] {
        ST_READY        = 2'd0,
        ST_WAIT_BASE    = 2'd1,
        ST_WAIT_CASCADE = 2'd2,
        ST_WAIT_MODE    = 2'd3
    } init_st_t;

    typedef enum logic [2:0] {
        OP_ROT_OFF   = 3'd0,
        OP_EOI_TOP   = 3'd1,
        OP_NOP       = 3'd2,
        OP_EOI_IDX   = 3'd3,
        OP_ROT_ON    = 3'd4,
        OP_EOI_TOP_R = 3'd5,
        OP_SET_BASE  = 3'd6,
        OP_EOI_IDX_R = 3'd7
    } op_code_t;
endpackage

// File: rtl/ictl_prio_pick.sv
module ictl_prio_pick #(
    parameter int W  = 8,
    parameter int IW = 3
) (
    input  logic [W-1:0]  bits,
    input  logic [IW-1:0] base,
    output logic          any,
    output logic [IW-1:0] idx
);
    logic [IW-1:0] pos [W];

    // rotated scan positions, one per rank
    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_pos
            assign pos[g] = IW'(base + IW'(g));
        end
    endgenerate

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int k = W - 1; k >= 0; k--) begin
            if (bits[pos[k]]) begin
                any = 1'b1;
                idx = pos[k];
            end
        end
    end
endmodule

// File: rtl/ictl_init_seq.sv
module ictl_init_seq
    import ictl_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start,
    input  logic     data_wr,
    input  logic     want_mode,
    output init_st_t st,
    output logic     take_base,
    output logic     take_mode,
    output logic     take_mask
);
    init_st_t nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_READY;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        if (start) begin
            nxt = ST_WAIT_BASE;
        end else if (data_wr) begin
            unique case (st)
                ST_READY:        nxt = ST_READY;
                ST_WAIT_BASE:    nxt = ST_WAIT_CASCADE;
                ST_WAIT_CASCADE: nxt = want_mode ? ST_WAIT_MODE : ST_READY;
                ST_WAIT_MODE:    nxt = ST_READY;
            endcase
        end
    end

    always_comb begin
        take_base = 1'b0;
        take_mode = 1'b0;
        take_mask = 1'b0;
        if (data_wr && !start) begin
            unique case (st)
                ST_READY:        take_mask = 1'b1;
                ST_WAIT_BASE:    take_base = 1'b1;
                ST_WAIT_CASCADE: ;
                ST_WAIT_MODE:    take_mode = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/ictl_port_decoder.sv
module ictl_port_decoder
    import ictl_pkg::*;
#(
    parameter bit          IS_SECONDARY  = 1'b0,
    parameter logic [7:0]  PRI_TRIG_MASK = 8'hF8,
    parameter logic [7:0]  SEC_TRIG_MASK = 8'hDE
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_wr,
    input  logic         bus_rd,
    input  logic         bus_addr,
    input  logic         bus_trig_sel,
    input  logic [7:0]   bus_wdata,
    output logic [7:0]   bus_rdata,
    input  logic [7:0]   core_irr,
    input  logic [7:0]   core_isr,
    input  logic         core_pend_valid,
    input  logic [2:0]   core_pend_idx,
    output logic         slice_init,
    output logic [7:0]   mask_reg,
    output logic [7:0]   vector_base,
    output logic         nest_mode,
    output logic         auto_eoi,
    output logic         rot_on_aeoi,
    output logic         special_mask,
    output logic [2:0]   prio_base,
    output logic [7:0]   trig_mode,
    output logic         isr_clr,
    output logic [2:0]   isr_clr_idx,
    output logic         irr_clr
);
    localparam logic [DATA_W-1:0] TRIG_MASK = IS_SECONDARY ? SEC_TRIG_MASK : PRI_TRIG_MASK;
    localparam logic [DATA_W-1:0] BASE_MASK = ~DATA_W'(LINES - 1);
    localparam logic [DATA_W-1:0] NO_PEND   = DATA_W'(LINES - 1);

    // bus decode
    logic     wr_cmd, wr_dat, wr_trig;
    logic     is_init, is_mode, is_op;
    logic     poll_rd;
    op_code_t op;

    assign wr_cmd  = bus_wr && !bus_trig_sel && !bus_addr;
    assign wr_dat  = bus_wr && !bus_trig_sel &&  bus_addr;
    assign wr_trig = bus_wr &&  bus_trig_sel;
    assign is_init = wr_cmd &&  bus_wdata[4];
    assign is_mode = wr_cmd && !bus_wdata[4] &&  bus_wdata[3];
    assign is_op   = wr_cmd && !bus_wdata[4] && !bus_wdata[3];
    assign op      = op_code_t'(bus_wdata[7:5]);

    // state
    logic [7:0] imr_q, base_q, trig_q;
    logic       nest_q, aeoi_q, rot_q, smm_q, rdsel_q, poll_q, want_q;
    logic [2:0] pb_q;
    logic       init_q, isrclr_q, irrclr_q;
    logic [2:0] clridx_q;

    init_st_t seq_st;
    logic     take_base, take_mode, take_mask;

    ictl_init_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (is_init),
        .data_wr   (wr_dat),
        .want_mode (want_q),
        .st        (seq_st),
        .take_base (take_base),
        .take_mode (take_mode),
        .take_mask (take_mask)
    );

    logic       top_any;
    logic [2:0] top_idx;

    ictl_prio_pick #(.W(LINES), .IW(IDX_W)) u_pick (
        .bits (core_isr),
        .base (pb_q),
        .any  (top_any),
        .idx  (top_idx)
    );

    // operation-code effects
    logic       op_clr;
    logic [2:0] op_idx;
    logic       op_pb_wr;
    logic [2:0] op_pb;
    logic       op_rot_wr;

    always_comb begin
        op_clr    = 1'b0;
        op_idx    = bus_wdata[2:0];
        op_pb_wr  = 1'b0;
        op_pb     = bus_wdata[2:0] + 3'd1;
        op_rot_wr = 1'b0;
        unique case (op)
            OP_ROT_OFF, OP_ROT_ON: op_rot_wr = 1'b1;
            OP_EOI_TOP: begin
                op_clr = top_any;
                op_idx = top_idx;
            end
            OP_EOI_TOP_R: begin
                op_clr   = top_any;
                op_idx   = top_idx;
                op_pb_wr = top_any;
                op_pb    = top_idx + 3'd1;
            end
            OP_EOI_IDX:   op_clr = 1'b1;
            OP_SET_BASE:  op_pb_wr = 1'b1;
            OP_EOI_IDX_R: begin
                op_clr   = 1'b1;
                op_pb_wr = 1'b1;
            end
            OP_NOP: ;
        endcase
    end

    assign poll_rd = bus_rd && !bus_trig_sel && poll_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            imr_q    <= '0;
            base_q   <= '0;
            trig_q   <= '0;
            nest_q   <= 1'b0;
            aeoi_q   <= 1'b0;
            rot_q    <= 1'b0;
            smm_q    <= 1'b0;
            rdsel_q  <= 1'b0;
            poll_q   <= 1'b0;
            want_q   <= 1'b0;
            pb_q     <= '0;
            init_q   <= 1'b0;
            isrclr_q <= 1'b0;
            irrclr_q <= 1'b0;
            clridx_q <= '0;
        end else begin
            init_q   <= is_init;
            isrclr_q <= 1'b0;
            irrclr_q <= 1'b0;
            if (wr_trig) trig_q <= bus_wdata & TRIG_MASK;
            if (is_init) begin
                imr_q   <= '0;
                base_q  <= '0;
                nest_q  <= 1'b0;
                aeoi_q  <= 1'b0;
                rot_q   <= 1'b0;
                smm_q   <= 1'b0;
                rdsel_q <= 1'b0;
                poll_q  <= 1'b0;
                pb_q    <= '0;
                want_q  <= bus_wdata[0];
            end else begin
                if (take_mask) imr_q  <= bus_wdata;
                if (take_base) base_q <= bus_wdata & BASE_MASK;
                if (take_mode) begin
                    nest_q <= bus_wdata[4];
                    aeoi_q <= bus_wdata[1];
                end
                if (poll_rd) begin
                    poll_q <= 1'b0;
                    if (core_pend_valid) begin
                        isrclr_q <= 1'b1;
                        irrclr_q <= 1'b1;
                        clridx_q <= core_pend_idx;
                    end
                end
                if (is_mode) begin
                    if (bus_wdata[2]) poll_q  <= 1'b1;
                    if (bus_wdata[1]) rdsel_q <= bus_wdata[0];
                    if (bus_wdata[6]) smm_q   <= bus_wdata[5];
                end
                if (is_op) begin
                    if (op_rot_wr) rot_q <= bus_wdata[7];
                    if (op_pb_wr)  pb_q  <= op_pb;
                    if (op_clr) begin
                        isrclr_q <= 1'b1;
                        irrclr_q <= 1'b0;
                        clridx_q <= op_idx;
                    end
                end
            end
        end
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (bus_trig_sel)       bus_rdata = trig_q;
            else if (poll_q)        bus_rdata = core_pend_valid ? {5'b0, core_pend_idx} : NO_PEND;
            else if (bus_addr)      bus_rdata = imr_q;
            else if (rdsel_q)       bus_rdata = core_isr;
            else                    bus_rdata = core_irr;
        end
    end

    assign slice_init   = init_q;
    assign mask_reg     = imr_q;
    assign vector_base  = base_q;
    assign nest_mode    = nest_q;
    assign auto_eoi     = aeoi_q;
    assign rot_on_aeoi  = rot_q;
    assign special_mask = smm_q;
    assign prio_base    = pb_q;
    assign trig_mode    = trig_q;
    assign isr_clr      = isrclr_q;
    assign isr_clr_idx  = clridx_q;
    assign irr_clr      = irrclr_q;
endmodule

// File: rtl/ictl_port_checker.sv
module ictl_port_checker
    import ictl_pkg::*;
#(
    parameter logic [7:0] TRIG_MASK = 8'hF8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic       bus_addr,
    input logic       bus_trig_sel,
    input logic [7:0] bus_wdata,
    input logic [7:0] core_isr,
    input logic       slice_init,
    input logic [7:0] mask_reg,
    input logic [7:0] vector_base,
    input logic       auto_eoi,
    input logic [2:0] prio_base,
    input logic [7:0] trig_mode,
    input logic       isr_clr,
    input init_st_t   st
);
    logic cmd_w, dat_w;
    assign cmd_w = bus_wr && !bus_trig_sel && !bus_addr;
    assign dat_w = bus_wr && !bus_trig_sel &&  bus_addr;

    a_r1_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w && bus_wdata[4]) |=>
        (slice_init && mask_reg == 8'h00 && prio_base == 3'd0 && !auto_eoi && st == ST_WAIT_BASE));

    a_r2_base_step: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_w && st == ST_WAIT_BASE) |=>
        (st == ST_WAIT_CASCADE && vector_base[2:0] == 3'd0));

    a_r5_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_w && st == ST_READY) |=> (mask_reg == $past(bus_wdata)));

    a_r8_no_idle_eoi: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w && bus_wdata[7:3] == 5'b00100 && core_isr == 8'h00) |=> !isr_clr);

    a_r12_trig_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_trig_sel) |=> (trig_mode == ($past(bus_wdata) & TRIG_MASK)));

    a_r13_init_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        slice_init |-> $past(cmd_w && bus_wdata[4]));
endmodule

bind ictl_port_decoder ictl_port_checker #(.TRIG_MASK(TRIG_MASK)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_trig_sel (bus_trig_sel),
    .bus_wdata    (bus_wdata),
    .core_isr     (core_isr),
    .slice_init   (slice_init),
    .mask_reg     (mask_reg),
    .vector_base  (vector_base),
    .auto_eoi     (auto_eoi),
    .prio_base    (prio_base),
    .trig_mode    (trig_mode),
    .isr_clr      (isr_clr),
    .st           (seq_st)
);

// File: tb/sim_ictl_port_decoder.sv
`timescale 1ns/1ps
module sim_ictl_port_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 0, bus_rd = 0, bus_addr = 0, bus_trig_sel = 0;
    logic [7:0] bus_wdata = 0, core_irr = 0, core_isr = 0;
    logic       core_pend_valid = 0;
    logic [2:0] core_pend_idx = 0;

    logic [7:0] rdata, mask_reg, vector_base, trig_mode;
    logic       slice_init, nest_mode, auto_eoi, rot_on_aeoi, special_mask, isr_clr, irr_clr;
    logic [2:0] prio_base, isr_clr_idx;

    logic [7:0] s_rdata, s_mask, s_base, s_trig;
    logic       s_init, s_nest, s_aeoi, s_rot, s_smm, s_iclr, s_rclr;
    logic [2:0] s_pb, s_idx;

    always #2.5 clk = ~clk;

    ictl_port_decoder u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_trig_sel(bus_trig_sel), .bus_wdata(bus_wdata), .bus_rdata(rdata),
        .core_irr(core_irr), .core_isr(core_isr), .core_pend_valid(core_pend_valid),
        .core_pend_idx(core_pend_idx), .slice_init(slice_init), .mask_reg(mask_reg),
        .vector_base(vector_base), .nest_mode(nest_mode), .auto_eoi(auto_eoi),
        .rot_on_aeoi(rot_on_aeoi), .special_mask(special_mask), .prio_base(prio_base),
        .trig_mode(trig_mode), .isr_clr(isr_clr), .isr_clr_idx(isr_clr_idx), .irr_clr(irr_clr)
    );

    ictl_port_decoder #(.IS_SECONDARY(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_trig_sel(bus_trig_sel), .bus_wdata(bus_wdata), .bus_rdata(s_rdata),
        .core_irr(core_irr), .core_isr(core_isr), .core_pend_valid(core_pend_valid),
        .core_pend_idx(core_pend_idx), .slice_init(s_init), .mask_reg(s_mask),
        .vector_base(s_base), .nest_mode(s_nest), .auto_eoi(s_aeoi),
        .rot_on_aeoi(s_rot), .special_mask(s_smm), .prio_base(s_pb),
        .trig_mode(s_trig), .isr_clr(s_iclr), .isr_clr_idx(s_idx), .irr_clr(s_rclr)
    );

    int checks = 0, failures = 0;
    bit done = 0;

    // reference model
    logic [7:0] m_imr, m_base, m_trig, m_trig2;
    logic       m_nest, m_aeoi, m_rot, m_smm, m_rdsel, m_poll, m_want;
    logic [2:0] m_pb;
    int         m_st;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] top_pick(input logic [7:0] isr, input logic [2:0] pb);
        for (int k = 0; k < 8; k++) begin
            logic [2:0] p;
            p = pb + 3'(k);
            if (isr[p]) return {1'b1, p};
        end
        return 4'h0;
    endfunction

    task automatic check_regs(input string tag);
        chk({tag, " regs"}, {mask_reg, vector_base, nest_mode, auto_eoi, rot_on_aeoi, special_mask, prio_base},
            {m_imr, m_base, m_nest, m_aeoi, m_rot, m_smm, m_pb});
        chk("R12 trig primary", trig_mode, m_trig);
        chk("R12 trig secondary", s_trig, m_trig2);
    endtask

    task automatic do_wr(input bit trig, input bit a, input logic [7:0] d);
        string tag;
        bit e_init, e_clr;
        logic [2:0] e_idx;
        logic [3:0] pk;
        e_init = 0; e_clr = 0; e_idx = 0; tag = "R13";
        @(negedge clk);
        bus_wr = 1; bus_trig_sel = trig; bus_addr = a; bus_wdata = d;
        if (trig) begin
            tag = "R12"; m_trig = d & 8'hF8; m_trig2 = d & 8'hDE;
        end else if (!a) begin
            if (d[4]) begin
                tag = "R1"; e_init = 1;
                m_imr = 0; m_base = 0; m_nest = 0; m_aeoi = 0; m_rot = 0; m_smm = 0;
                m_rdsel = 0; m_poll = 0; m_pb = 0; m_want = d[0]; m_st = 1;
            end else if (d[3]) begin
                tag = "R6";
                if (d[2]) m_poll = 1;
                if (d[1]) m_rdsel = d[0];
                if (d[6]) m_smm = d[5];
            end else begin
                case (d[7:5])
                    3'd0, 3'd4, 3'd2: begin tag = "R7"; if (d[7:5] != 3'd2) m_rot = d[7]; end
                    3'd1, 3'd5: begin
                        tag = "R8";
                        pk = top_pick(core_isr, m_pb);
                        e_clr = pk[3]; e_idx = pk[2:0];
                        if (pk[3] && d[7:5] == 3'd5) m_pb = pk[2:0] + 3'd1;
                    end
                    3'd3: begin tag = "R9"; e_clr = 1; e_idx = d[2:0]; end
                    3'd6: begin tag = "R9"; m_pb = d[2:0] + 3'd1; end
                    default: begin tag = "R9"; e_clr = 1; e_idx = d[2:0]; m_pb = d[2:0] + 3'd1; end
                endcase
            end
        end else begin
            case (m_st)
                0: begin tag = "R5"; m_imr = d; end
                1: begin tag = "R2"; m_base = d & 8'hF8; m_st = 2; end
                2: begin tag = "R3"; m_st = m_want ? 3 : 0; end
                default: begin tag = "R4"; m_nest = d[4]; m_aeoi = d[1]; m_st = 0; end
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        bus_wr = 0;
        check_regs(tag);
        chk({tag, " R13 init pulse"}, slice_init, e_init);
        chk({tag, " R13 isr_clr"}, isr_clr, e_clr);
        chk({tag, " irr_clr"}, irr_clr, 1'b0);
        if (e_clr) chk({tag, " clr idx"}, isr_clr_idx, e_idx);
    endtask

    task automatic do_rd(input bit trig, input bit a);
        logic [7:0] exp;
        string tag;
        bit was_poll;
        @(negedge clk);
        bus_rd = 1; bus_trig_sel = trig; bus_addr = a;
        was_poll = !trig && m_poll;
        if (trig) begin tag = "R12 read"; exp = m_trig; end
        else if (m_poll) begin tag = "R11 poll"; exp = core_pend_valid ? {5'b0, core_pend_idx} : 8'd7; end
        else if (a) begin tag = "R10 mask"; exp = m_imr; end
        else begin tag = "R10 sel"; exp = m_rdsel ? core_isr : core_irr; end
        #1;
        chk(tag, rdata, exp);
        @(posedge clk);
        @(negedge clk);
        bus_rd = 0;
        if (was_poll) begin
            chk("R11 isr_clr", isr_clr, core_pend_valid);
            chk("R11 irr_clr", irr_clr, core_pend_valid);
            if (core_pend_valid) chk("R11 idx", isr_clr_idx, core_pend_idx);
            m_poll = 0;
        end else begin
            chk("R10 no strobe", isr_clr, 1'b0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        m_imr = 0; m_base = 0; m_trig = 0; m_trig2 = 0; m_nest = 0; m_aeoi = 0; m_rot = 0;
        m_smm = 0; m_rdsel = 0; m_poll = 0; m_want = 0; m_pb = 0; m_st = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_regs("R1 reset");
        chk("R13 reset strobes", {slice_init, isr_clr, irr_clr}, 3'b000);

        // trigger-mode before init, must survive init
        do_wr(1, 0, 8'hFF);
        // init with mode word
        do_wr(0, 0, 8'h11);
        do_rd(1, 0);
        do_wr(0, 1, 8'h6F);
        do_wr(0, 1, 8'hAA);
        do_wr(0, 1, 8'h12);
        do_wr(0, 1, 8'h5A);
        do_rd(0, 1);
        // init without mode word
        do_wr(0, 0, 8'h10);
        do_wr(0, 1, 8'h27);
        do_wr(0, 1, 8'hFF);
        do_wr(0, 1, 8'h3C);
        // read select
        core_irr = 8'h81; core_isr = 8'h24;
        do_rd(0, 0);
        do_wr(0, 0, 8'h0B);
        do_rd(0, 0);
        do_wr(0, 0, 8'h0A);
        do_rd(0, 0);
        // special mask set/clear and no-op code 2
        do_wr(0, 0, 8'h68);
        do_wr(0, 0, 8'h48);
        do_wr(0, 0, 8'h47);
        // rotation: base 5, isr bits 0 and 5 -> 5 wins
        do_wr(0, 0, 8'hC4);
        core_isr = 8'h21;
        do_wr(0, 0, 8'hA0);
        core_isr = 8'h01;
        do_wr(0, 0, 8'h20);
        core_isr = 8'h00;
        do_wr(0, 0, 8'h20);
        do_wr(0, 0, 8'hE7);
        do_wr(0, 0, 8'h80);
        do_wr(0, 0, 8'h00);
        // poll with and without a pending line
        core_pend_valid = 1; core_pend_idx = 3'd6;
        do_wr(0, 0, 8'h0C);
        do_rd(0, 1);
        core_pend_valid = 0;
        do_wr(0, 0, 8'h0C);
        do_rd(0, 0);
        do_rd(0, 1);

        // constrained random mix
        for (int i = 0; i < 600; i++) begin
            int sel;
            logic [7:0] d;
            sel = $urandom_range(0, 19);
            d = 8'($urandom);
            core_irr = 8'($urandom);
            core_isr = ($urandom_range(0, 3) == 0) ? 8'h00 : 8'($urandom);
            core_pend_valid = 1'($urandom);
            core_pend_idx = 3'($urandom);
            if (sel == 0)       do_wr(0, 0, d | 8'h10);
            else if (sel < 5)   do_wr(0, 1, d);
            else if (sel < 8)   do_wr(0, 0, (d & 8'hE7) | 8'h08);
            else if (sel < 12)  do_wr(0, 0, d & 8'hE7);
            else if (sel < 14)  do_wr(1, 1'($urandom), d);
            else                do_rd(1'(sel == 19), 1'($urandom));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule